// File: doc/BRIEF.md
# Direct-Mapped Configuration Address Translator

This block sits on the CPU bus and claims accesses that land in a fixed 4 MB window at 0x8080_0000. For each claimed access it issues one PCI configuration request to a downstream target. The device number in that request comes from a one-hot select field inside the CPU address. The block scans that field for its lowest set bit and encodes the bit's index in binary. Register offset bits and function bits pass through untouched.

The CPU side uses a request/acknowledge handshake. The CPU holds `cpu_req` until `cpu_ack` pulses, and only one configuration request is outstanding at any time. Data is moved little-endian. Write data arrives right-aligned and is steered onto the byte lanes that the low address bits select. Read data is steered back to the right-aligned position. If the target never answers, a timeout completes the access. Accesses outside the window, or accesses of an unsupported size, are left alone so that another decoder can claim them.

Top module: `cfg_window_xlate`

## Requirements
- R1: An access with `cpu_addr` in [0x8080_0000, 0x80C0_0000) and a supported size (`cpu_size` of 1, 2 or 4) produces exactly one configuration request, followed by one `cpu_ack` pulse.
- R2: The select field is window-relative address bits [21:11]. The lowest set bit among them, bit 11+k, puts device number k into `cfg_addr[14:11]`.
- R3: When bits [21:11] are all zero, `cfg_addr[14:11]` is 11.
- R4: `cfg_addr[10:0]` equals `cpu_addr[10:0]`.
- R5: Byte enables `cfg_be` equal the lane mask (1 byte `0001`, 2 bytes `0011`, 4 bytes `1111`) shifted left by `cpu_addr[1:0]` and cut to 4 bits. `cfg_wdata` is `cpu_wdata` shifted left by 8*`cpu_addr[1:0]`.
- R6: `cpu_rdata` is `cfg_rdata` shifted right by 8*`cpu_addr[1:0]`. Only the low `cpu_size` bytes are kept, and the upper bytes read as zero.
- R7: If `cfg_rdy` has not arrived after TIMEOUT cycles of `cfg_req`, the block drops `cfg_req` and acknowledges the CPU. A read completed this way returns ones in the accessed bytes and zero above them.
- R8: An address outside the window, or a `cpu_size` other than 1, 2 or 4, raises neither `cfg_req` nor `cpu_ack`.
- R9: `cfg_req` and `cfg_addr` stay stable until `cfg_rdy` or the timeout. `cpu_ack` is a single-cycle pulse in the cycle after the response.
- R10: `cfg_we` carries the direction of the CPU access (1 for write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 3 | Access size in bytes (1, 2 or 4) |
| cpu_wdata | input | 32 | Right-aligned write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Right-aligned read data, valid with `cpu_ack` |
| cfg_req | output | 1 | Configuration request to the target |
| cfg_we | output | 1 | Configuration write |
| cfg_addr | output | 15 | Device number in [14:11], offset bits in [10:0] |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-steered write data |
| cfg_rdy | input | 1 | Target response strobe |
| cfg_rdata | input | 32 | Target read data, valid with `cfg_rdy` |

## Verification
The bench keeps the default window base, window size and select position. Each of the eleven select bits, a two-bit pattern and the all-zero select field can therefore be driven directly, along with the addresses just below and just above the window. TIMEOUT is set to 8, which puts the silent-target path within a few cycles. The bench can then count the exact number of request cycles before the forced completion and check the all-ones read data.

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate #(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_LOG2 = 22,
  parameter int SEL_LSB  = 11,
  parameter int TIMEOUT  = 256,
  localparam int SEL_W   = WIN_LOG2 - SEL_LSB,
  localparam int DEV_W   = $clog2(SEL_W + 1),
  localparam int CFG_AW  = SEL_LSB + DEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_addr,
  input  logic [2:0]        cpu_size,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ack,
  output logic [31:0]       cpu_rdata,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [3:0]        cfg_be,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_rdy,
  input  logic [31:0]       cfg_rdata
);
  localparam int TO_W = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_t;
  state_t st;

  logic [TO_W-1:0] cnt;
  logic [1:0]      off_q;
  logic [31:0]     keep_q;
  logic [31:0]     rdata_q;
  logic [DEV_W-1:0] dev_n;
  logic [3:0]      lanes;
  logic [31:0]     keep_n;

  wire in_win  = cpu_addr[31:WIN_LOG2] == WIN_BASE[31:WIN_LOG2];
  wire size_ok = (cpu_size == 3'd1) || (cpu_size == 3'd2) || (cpu_size == 3'd4);
  wire claim   = cpu_req && in_win && size_ok;
  wire expired = cnt == TO_W'(TIMEOUT - 1);

  always_comb begin
    dev_n = DEV_W'(SEL_W);
    for (int i = SEL_W - 1; i >= 0; i--)
      if (cpu_addr[SEL_LSB + i]) dev_n = DEV_W'(i);
  end

  always_comb begin
    case (cpu_size)
      3'd1:    begin lanes = 4'b0001; keep_n = 32'h0000_00FF; end
      3'd2:    begin lanes = 4'b0011; keep_n = 32'h0000_FFFF; end
      default: begin lanes = 4'b1111; keep_n = 32'hFFFF_FFFF; end
    endcase
  end

  assign cfg_req   = st == S_BUSY;
  assign cpu_ack   = st == S_DONE;
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      off_q     <= '0;
      keep_q    <= '0;
      rdata_q   <= '0;
      cfg_we    <= 1'b0;
      cfg_addr  <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (claim) begin
          st        <= S_BUSY;
          cnt       <= '0;
          off_q     <= cpu_addr[1:0];
          keep_q    <= keep_n;
          cfg_we    <= cpu_we;
          cfg_addr  <= {dev_n, cpu_addr[SEL_LSB-1:0]};
          cfg_be    <= 4'(lanes << cpu_addr[1:0]);
          cfg_wdata <= cpu_wdata << {cpu_addr[1:0], 3'b000};
        end
        S_BUSY: begin
          if (cfg_rdy) begin
            st      <= S_DONE;
            rdata_q <= (cfg_rdata >> {off_q, 3'b000}) & keep_q;
          end else if (expired) begin
            st      <= S_DONE;
            rdata_q <= keep_q;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_rdy && !expired) |=> (cfg_req && $stable(cfg_addr))); // R9
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack); // R9
  AST_ACK_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ack) |-> $past(cfg_req)); // R8
  AST_CFG_FROM_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> $past(cpu_req)); // R1
  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_be != 4'b0000)); // R5
  AST_DEV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_addr[CFG_AW-1:SEL_LSB] <= DEV_W'(SEL_W))); // R3
endmodule

// File: tb/cfg_window_xlate_tb.sv
module cfg_window_xlate_tb;
  localparam logic [31:0] BASE = 32'h8080_0000;
  localparam int TO = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [2:0] cpu_size = 3'd4;
  logic cpu_ack, cfg_req, cfg_we;
  logic [31:0] cpu_rdata, cfg_wdata;
  logic [14:0] cfg_addr;
  logic [3:0] cfg_be;
  logic cfg_rdy = 0;
  logic [31:0] cfg_rdata = 0;

  int checks = 0, fails = 0;
  logic tgt_en = 1'b1;
  int hs_count = 0, req_cycles = 0;
  logic [14:0] last_addr;
  logic [3:0] last_be;
  logic [31:0] last_wdata;
  logic last_we;
  logic [31:0] mem [64];

  cfg_window_xlate #(.TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .cfg_req(cfg_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdy(cfg_rdy), .cfg_rdata(cfg_rdata));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (cfg_req) req_cycles++;
    if (tgt_en && cfg_req && !cfg_rdy) begin
      int idx;
      idx = {cfg_addr[14:11], cfg_addr[3:2]};
      last_addr = cfg_addr; last_be = cfg_be; last_wdata = cfg_wdata; last_we = cfg_we;
      hs_count++;
      cfg_rdata = mem[idx];
      if (cfg_we)
        for (int b = 0; b < 4; b++)
          if (cfg_be[b]) mem[idx][8*b +: 8] = cfg_wdata[8*b +: 8];
      cfg_rdy = 1'b1;
    end else begin
      cfg_rdy = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] addr, input logic [2:0] size,
                        input logic [31:0] wd, output logic [31:0] rd, output logic acked);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_size = size; cpu_wdata = wd;
    req_cycles = 0;
    acked = 0; rd = 0;
    for (int c = 0; c < 30; c++) begin
      @(posedge clk); @(negedge clk);
      if (cpu_ack) begin acked = 1; rd = cpu_rdata; break; end
    end
    cpu_req = 0;
    @(posedge clk); @(negedge clk);
    chk("R9 ack single pulse", {31'b0, cpu_ack}, 32'd0);
  endtask

  function automatic logic [3:0] exp_dev(input logic [31:0] a);
    exp_dev = 4'd11;
    for (int k = 10; k >= 0; k--) if (a[11 + k]) exp_dev = 4'(k);
  endfunction

  task automatic t_reset();
    chk("R9 reset ack low", {31'b0, cpu_ack}, 32'd0);
    chk("R1 reset cfg_req low", {31'b0, cfg_req}, 32'd0);
  endtask

  task automatic t_dev_decode();
    logic [31:0] rd, a; logic ok; int h0;
    for (int k = 0; k < 11; k++) begin
      a = BASE | (32'h1 << (11 + k)) | 32'h004;
      h0 = hs_count;
      access(1, a, 3'd1, 32'(k), rd, ok);
      chk("R1 acked", {31'b0, ok}, 32'd1);
      chk("R1 one handshake", 32'(hs_count - h0), 32'd1);
      chk("R2 device number", {28'b0, last_addr[14:11]}, {28'b0, exp_dev(a)});
      chk("R10 write flag", {31'b0, last_we}, 32'd1);
    end
    a = BASE | (32'h1 << 13) | (32'h1 << 17);
    access(0, a, 3'd4, 0, rd, ok);
    chk("R2 lowest of two bits", {28'b0, last_addr[14:11]}, 32'd2);
    chk("R10 read flag", {31'b0, last_we}, 32'd0);
    access(0, BASE | 32'h020, 3'd4, 0, rd, ok);
    chk("R3 empty select -> 11", {28'b0, last_addr[14:11]}, 32'd11);
  endtask

  task automatic t_low_bits();
    logic [31:0] rd; logic ok;
    access(0, BASE | (32'h1 << 15) | 32'h5A7, 3'd1, 0, rd, ok);
    chk("R4 offset passthrough", {21'b0, last_addr[10:0]}, 32'h5A7);
    chk("R5 byte lane 3", {28'b0, last_be}, 32'h8);
    chk("R6 unwritten byte", rd, 32'h0);
  endtask

  task automatic t_data_lanes();
    logic [31:0] rd, a; logic ok;
    a = BASE | (32'h1 << 14) | 32'h010;
    access(1, a, 3'd4, 32'hA1B2C3D4, rd, ok);
    chk("R5 word be", {28'b0, last_be}, 32'hF);
    chk("R5 word data", last_wdata, 32'hA1B2C3D4);
    access(0, a, 3'd4, 0, rd, ok);
    chk("R6 word readback", rd, 32'hA1B2C3D4);
    access(1, a + 2, 3'd2, 32'h0000_5566, rd, ok);
    chk("R5 half be", {28'b0, last_be}, 32'hC);
    chk("R5 half data shifted", last_wdata, 32'h5566_0000);
    access(0, a + 3, 3'd1, 0, rd, ok);
    chk("R6 byte read offset 3", rd, 32'h55);
    access(0, a, 3'd2, 0, rd, ok);
    chk("R6 half read offset 0", rd, 32'hC3D4);
  endtask

  task automatic t_outside();
    logic [31:0] rd; logic ok; int h0;
    h0 = hs_count;
    access(0, BASE - 4, 3'd4, 0, rd, ok);
    chk("R8 below window no ack", {31'b0, ok}, 32'd0);
    chk("R8 below window no cfg", 32'(req_cycles), 32'd0);
    access(1, BASE + 32'h0040_0000, 3'd4, 32'h1, rd, ok);
    chk("R8 above window no ack", {31'b0, ok}, 32'd0);
    access(0, BASE | 32'h100, 3'd3, 0, rd, ok);
    chk("R8 bad size no ack", {31'b0, ok}, 32'd0);
    chk("R8 no handshakes", 32'(hs_count - h0), 32'd0);
  endtask

  task automatic t_timeout();
    logic [31:0] rd; logic ok;
    tgt_en = 0;
    access(0, BASE | (32'h1 << 12) | 32'h002, 3'd2, 0, rd, ok);
    chk("R7 timeout acked", {31'b0, ok}, 32'd1);
    chk("R7 timeout read ones", rd, 32'h0000_FFFF);
    chk("R7 request cycles", 32'(req_cycles), 32'(TO));
    access(1, BASE | 32'h008, 3'd4, 32'h5, rd, ok);
    chk("R7 timeout write acked", {31'b0, ok}, 32'd1);
    tgt_en = 1;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_dev_decode();
    t_low_bits();
    t_data_lanes();
    t_outside();
    t_timeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule